// File: doc/BRIEF.md
# GPIO Port Register File with Masked-Write Aliases

This block holds the control state for one bank of general-purpose pins, organised as several ports of eight pins each. For every port it keeps three writable control bytes: a pin-enable byte that hands the pin to GPIO use rather than an alternate function, a drive-enable byte and a drive-value byte. A fourth, read-only byte shows the pad inputs after a two-flop synchronizer. The block drives the pad value, pad drive-enable and GPIO-enable lines from that state.

Software reaches the state through a single-cycle read/write port. Each writable control byte appears at two addresses. The plain address replaces the whole byte. A second alias, placed at a fixed upper offset above it, lets one write change a chosen subset of pins, so concurrent users never need a read-modify-write sequence. The bank base address is the bank index times the bank stride, and the stride, upper offset, bank index and port count are parameters.

Top module: `gpio_port_rf`

## Requirements
- R1: While `rst` is high and after it falls, every enable, drive-enable and drive-value bit is 0, so `pad_out`, `pad_oe`, `gpio_en` and `rdata` read 0.
- R2: A write to a plain address BASE + kind offset + port×4 replaces that port's byte with `wdata[7:0]` and ignores `wdata[31:8]`. BASE is BANK_ID×BANK_STRIDE, and the kind offsets are 0x00 for pin enable, 0x10 for drive enable and 0x20 for drive value.
- R3: A write to a masked alias (plain address + UPPER_OFFSET, for the three writable kinds) updates only the pins whose bit in `wdata[15:8]` is 1, taking their new values from `wdata[7:0]`. Other pins keep their values and `wdata[31:16]` is ignored.
- R4: `rd_en` returns the addressed byte zero-extended in `rdata` one cycle later, and `rdata` holds its value until the next read. Reads of masked aliases and of unmapped addresses return 0.
- R5: A read at plain offset 0x30 + port×4 returns the pad inputs of that port after a two-flop synchronizer. A pad change made before clock edge N shows up in a read requested at edge N+2.
- R6: Writes to the input offset 0x30 and to its would-be alias at 0x30 + UPPER_OFFSET change no state.
- R7: Pin number = port×8 + bit. `pad_out` carries the drive-value bit, `gpio_en` carries the pin-enable bit, and `pad_oe` is high only when both the drive-enable and pin-enable bits are 1.
- R8: Writes to addresses outside this bank's window, or with `addr[1:0]` not zero, change no state.
- R9: A read and a write to the same register in the same cycle return the value from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data; masked writes use [15:8] as the mask and [7:0] as the values |
| rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PORTS×PORT_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PORTS×PORT_PINS | Pad drive value |
| pad_oe | output | NUM_PORTS×PORT_PINS | Pad drive enable |
| gpio_en | output | NUM_PORTS×PORT_PINS | Pin assigned to GPIO use |

## Verification
A corrupted control bit shows up on `pad_out`, `pad_oe` or `gpio_en` in the cycle right after the write that caused it, because those lines come straight from the state. It also shows in `rdata` one cycle after any read of that port. A merge that uses the wrong mask is seen at once on the untouched pins of a masked write. A decode error appears as state changing after writes to the input, alias-of-input, foreign-bank or unaligned addresses. Synchronizer faults show as input reads that arrive a cycle early or late relative to a pad change.

// File: rtl/gpio_port_rf_pkg.sv
package gpio_port_rf_pkg;
  typedef enum logic [1:0] {
    RK_ENABLE = 2'd0,
    RK_DRIVE  = 2'd1,
    RK_VALUE  = 2'd2,
    RK_INPUT  = 2'd3
  } reg_kind_e;

  localparam int KIND_SPAN      = 'h10;
  localparam int PLAIN_WINDOW   = 4 * KIND_SPAN;
  localparam int MASKED_WINDOW  = 3 * KIND_SPAN;
  localparam int NUM_CTRL_KINDS = 3;
  localparam int DATA_W         = 32;
endpackage

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_full,
  input  logic         we_mask,
  input  logic [W-1:0] val,
  input  logic [W-1:0] sel,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (we_full) q <= val;
    else if (we_mask) q <= (q & ~sel) | (val & sel);
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_rf_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BASE      = 0,
  parameter int UPPER     = 'h80,
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_plain,
  output logic              hit_mask,
  output reg_kind_e         kind,
  output logic [PORT_W-1:0] port
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(BASE + UPPER);
  localparam logic [ADDR_W-1:0] PLAIN_N = ADDR_W'(PLAIN_WINDOW);
  localparam logic [ADDR_W-1:0] MASK_N  = ADDR_W'(MASKED_WINDOW);

  logic [ADDR_W-1:0] off_p, off_m, off_sel;
  logic [1:0]        port_raw_p, port_raw_m;

  always_comb begin
    off_p      = addr - BASE_A;
    off_m      = addr - MASK_A;
    port_raw_p = off_p[3:2];
    port_raw_m = off_m[3:2];
    hit_plain  = (addr >= BASE_A) && (off_p < PLAIN_N) && (off_p[1:0] == 2'b00)
                 && (32'(port_raw_p) < NUM_PORTS);
    hit_mask   = (addr >= MASK_A) && (off_m < MASK_N) && (off_m[1:0] == 2'b00)
                 && (32'(port_raw_m) < NUM_PORTS);
    off_sel    = hit_plain ? off_p : off_m;
    kind       = reg_kind_e'(off_sel[5:4]);
    port       = PORT_W'(off_sel[3:2]);
  end
endmodule

// File: rtl/gpio_port_rf.sv
module gpio_port_rf
  import gpio_port_rf_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BANK_ID      = 0,
  parameter int BANK_STRIDE  = 'h100,
  parameter int UPPER_OFFSET = 'h80,
  parameter int NUM_PORTS    = 4,
  parameter int PORT_PINS    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [31:0]                    wdata,
  output logic [31:0]                    rdata,
  input  logic [NUM_PORTS*PORT_PINS-1:0] pad_in,
  output logic [NUM_PORTS*PORT_PINS-1:0] pad_out,
  output logic [NUM_PORTS*PORT_PINS-1:0] pad_oe,
  output logic [NUM_PORTS*PORT_PINS-1:0] gpio_en
);
  localparam int NUM_PINS = NUM_PORTS * PORT_PINS;
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int BASE     = BANK_ID * BANK_STRIDE;

  logic              hit_plain, hit_mask;
  reg_kind_e         kind;
  logic [PORT_W-1:0] port;

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .UPPER(UPPER_OFFSET),
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)
  ) u_dec (
    .addr(addr), .hit_plain(hit_plain), .hit_mask(hit_mask),
    .kind(kind), .port(port)
  );

  logic [PORT_PINS-1:0] state_q [NUM_CTRL_KINDS][NUM_PORTS];
  logic [NUM_PINS-1:0]  in_sync;

  for (genvar k = 0; k < NUM_CTRL_KINDS; k++) begin : g_kind
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic sel_here;
      assign sel_here = (kind == reg_kind_e'(k)) && (port == PORT_W'(p));
      gpio_mask_reg #(.W(PORT_PINS)) u_reg (
        .clk(clk), .rst(rst),
        .we_full(wr_en && hit_plain && sel_here),
        .we_mask(wr_en && hit_mask && sel_here),
        .val(wdata[PORT_PINS-1:0]),
        .sel(wdata[2*PORT_PINS-1:PORT_PINS]),
        .q(state_q[k][p])
      );
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pads
    assign gpio_en[p*PORT_PINS +: PORT_PINS] = state_q[RK_ENABLE][p];
    assign pad_out[p*PORT_PINS +: PORT_PINS] = state_q[RK_VALUE][p];
    assign pad_oe [p*PORT_PINS +: PORT_PINS] = state_q[RK_DRIVE][p] & state_q[RK_ENABLE][p];
  end

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(in_sync)
  );

  logic [PORT_PINS-1:0] rd_byte;
  always_comb begin
    rd_byte = '0;
    if (hit_plain) begin
      case (kind)
        RK_ENABLE: rd_byte = state_q[RK_ENABLE][port];
        RK_DRIVE:  rd_byte = state_q[RK_DRIVE][port];
        RK_VALUE:  rd_byte = state_q[RK_VALUE][port];
        default:   rd_byte = in_sync[32'(port)*PORT_PINS +: PORT_PINS];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= DATA_W'(rd_byte);
  end
endmodule

// File: rtl/gpio_port_rf_chk.sv
module gpio_port_rf_chk #(
  parameter int ADDR_W       = 12,
  parameter int BANK_ID      = 0,
  parameter int BANK_STRIDE  = 'h100,
  parameter int UPPER_OFFSET = 'h80,
  parameter int NUM_PORTS    = 4,
  parameter int PORT_PINS    = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wr_en,
  input logic [ADDR_W-1:0]              addr,
  input logic [31:0]                    wdata,
  input logic [31:0]                    rdata,
  input logic [NUM_PORTS*PORT_PINS-1:0] pad_out,
  input logic [NUM_PORTS*PORT_PINS-1:0] pad_oe,
  input logic [NUM_PORTS*PORT_PINS-1:0] gpio_en
);
  localparam logic [ADDR_W-1:0] MASK_VALUE0 =
    ADDR_W'(BANK_ID * BANK_STRIDE + UPPER_OFFSET + 'h20);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_out == '0 && pad_oe == '0 && gpio_en == '0 && rdata == '0));

  // R7
  oe_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~gpio_en) == '0);

  // R4
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[31:PORT_PINS] == '0);

  // R8
  idle_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pad_out) && $stable(pad_oe) && $stable(gpio_en)));

  // R8
  unaligned_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[1:0] != 2'b00) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(gpio_en)));

  // R3
  masked_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == MASK_VALUE0) |=>
      (((pad_out[PORT_PINS-1:0] ^ $past(pad_out[PORT_PINS-1:0]))
        & ~$past(wdata[2*PORT_PINS-1:PORT_PINS])) == '0));
endmodule

bind gpio_port_rf gpio_port_rf_chk #(
  .ADDR_W(ADDR_W), .BANK_ID(BANK_ID), .BANK_STRIDE(BANK_STRIDE),
  .UPPER_OFFSET(UPPER_OFFSET), .NUM_PORTS(NUM_PORTS), .PORT_PINS(PORT_PINS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe), .gpio_en(gpio_en)
);

// File: tb/gpio_port_rf_bench.sv
`timescale 1ns/1ps
module gpio_port_rf_bench;
  localparam int AW = 12, BID = 1, STR = 'h100, UPO = 'h80, NP = 4, PP = 8;
  localparam int NPIN = NP * PP;
  localparam int BASE = BID * STR, MBASE = BASE + UPO;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic [NPIN-1:0] pad_in, pad_out, pad_oe, gpio_en;

  gpio_port_rf #(
    .ADDR_W(AW), .BANK_ID(BID), .BANK_STRIDE(STR), .UPPER_OFFSET(UPO),
    .NUM_PORTS(NP), .PORT_PINS(PP)
  ) u_gpio_port_rf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .gpio_en(gpio_en)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_reg [3][NP];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int a);
    int off;
    off = a - BASE;
    if (a >= BASE && off < 'h40 && (off % 4) == 0) begin
      if ((off >> 4) < 3) return 32'(m_reg[off >> 4][(off >> 2) & 3]);
      return 32'(pad_in[((off >> 2) & 3) * PP +: PP]);
    end
    return 32'h0;
  endfunction

  function automatic void model_write(int a, logic [31:0] d);
    int off, k, p;
    off = a - BASE;
    if (a >= BASE && off < 'h40 && (off % 4) == 0) begin
      k = off >> 4; p = (off >> 2) & 3;
      if (k < 3) m_reg[k][p] = d[7:0];
    end else begin
      off = a - MBASE;
      if (a >= MBASE && off < 'h30 && (off % 4) == 0) begin
        k = off >> 4; p = (off >> 2) & 3;
        m_reg[k][p] = (m_reg[k][p] & ~d[15:8]) | (d[7:0] & d[15:8]);
      end
    end
  endfunction

  task automatic check_pads(string tag);
    logic [NPIN-1:0] eo, eoe, een;
    for (int p = 0; p < NP; p++) begin
      een[p*PP +: PP] = m_reg[0][p];
      eoe[p*PP +: PP] = m_reg[1][p] & m_reg[0][p];
      eo [p*PP +: PP] = m_reg[2][p];
    end
    chk({tag, " pad_out"}, pad_out, eo);
    chk({tag, " pad_oe"},  pad_oe,  eoe);
    chk({tag, " gpio_en"}, gpio_en, een);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 0;
    model_write(a, d);
  endtask

  task automatic rd(int a, string tag);
    logic [31:0] e;
    e = exp_read(a);
    rd_en = 1; addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    chk(tag, rdata, e);
  endtask

  task automatic rw_same(int a, logic [31:0] d, string tag);
    logic [31:0] e;
    e = exp_read(a);
    wr_en = 1; rd_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk(tag, rdata, e);
    model_write(a, d);
  endtask

  task automatic set_pads(logic [NPIN-1:0] v);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic int rand_addr();
    int sel, p, k;
    sel = int'($urandom_range(0, 9));
    p = int'($urandom_range(0, NP - 1));
    if (sel < 4)  return BASE + sel * 16 + p * 4;
    if (sel < 7)  return MBASE + (sel - 4) * 16 + p * 4;
    if (sel == 7) return MBASE + 'h30 + p * 4;
    k = int'($urandom_range(0, 3));
    if (sel == 8) return k * 16 + p * 4;
    return BASE + k * 16 + p * 4 + int'($urandom_range(1, 3));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; pad_in = '0;
    for (int k = 0; k < 3; k++) for (int p = 0; p < NP; p++) m_reg[k][p] = '0;
    repeat (3) @(negedge clk);
    check_pads("R1 in reset");
    chk("R1 rdata in reset", rdata, 32'h0);
    rst = 0;
    @(negedge clk);
    check_pads("R1 after reset");
    rd(BASE + 'h20, "R1 value reg read");

    // R2: plain writes, upper bits ignored
    wr(BASE + 'h00 + 4, 32'hFFFF_FF5A);
    wr(BASE + 'h10 + 4, 32'h1234_560F);
    wr(BASE + 'h20 + 4, 32'hAAAA_AAC3);
    check_pads("R2 plain");
    check_pads("R7 mapping");
    rd(BASE + 'h20 + 4, "R2 read value");
    rd(BASE + 'h10 + 4, "R2 read drive");

    // R3: masked writes
    wr(MBASE + 'h20 + 4, 32'hFFFF_F00F);
    check_pads("R3 masked value");
    wr(MBASE + 'h00 + 4, 32'h0000_0000);
    check_pads("R3 zero mask no change");
    wr(MBASE + 'h10 + 12, 32'h0000_8181);
    check_pads("R3 masked drive port3");
    rd(MBASE + 'h20 + 4, "R4 alias read zero");
    rd(BASE + 'h40, "R4 unmapped read zero");

    // R5: input sync
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    rd_en = 1; addr = AW'(BASE + 'h30 + 8);
    @(negedge clk);
    rd_en = 0;
    chk("R5 input too early", rdata, 32'h0);
    repeat (2) @(negedge clk);
    rd(BASE + 'h30 + 8, "R5 input port2");
    rd(BASE + 'h30 + 12, "R5 input port3");

    // R6 / R8: ignored writes
    wr(BASE + 'h30, 32'hFFFF_FFFF);
    check_pads("R6 input write");
    wr(MBASE + 'h30, 32'hFFFF_FFFF);
    check_pads("R6 input alias write");
    wr('h020 + 4, 32'h0000_00FF);
    check_pads("R8 other bank");
    wr(BASE + 'h20 + 6, 32'h0000_00FF);
    check_pads("R8 unaligned");

    // R9: simultaneous read and write
    rw_same(BASE + 'h20 + 4, 32'h0000_0077, "R9 old value");
    rd(BASE + 'h20 + 4, "R9 new value");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int a, op;
      logic [31:0] d;
      if (i % 60 == 0) set_pads(NPIN'($urandom));
      a = rand_addr();
      d = $urandom;
      op = int'($urandom_range(0, 3));
      if (op < 2) begin
        wr(a, d);
        check_pads("R2 R3 R6 R8 random write");
      end else if (op == 2) begin
        rd(a, "R4 R5 random read");
      end else begin
        rw_same(a, d, "R9 random");
        check_pads("R9 random pads");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule